// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block sits between a two-wire serial slave and a byte-wide non-volatile array of 1024 bytes arranged as 64 rows of 16 bytes. A write command first opens with a start address. The data bytes that follow are gathered into a 16-entry page store, and a per-slot valid bit marks each slot that has received a byte. Only the low four address bits advance from byte to byte, so the target row never changes. When more than sixteen bytes arrive, the in-page pointer wraps and the newer bytes replace the older ones.

The stop that ends the command arrives as a one-cycle commit pulse. On commit the block enters a self-timed write cycle. It first waits a programmable number of clock cycles that stands in for the programming time. It then walks all sixteen slots in ascending order, one per clock, and pulses the array write enable only for the valid slots. A busy flag covers the whole cycle, and every control input is ignored while it is high. An active write-protect input at commit discards the page without touching the array. An abort pulse, or a new start that arrives before a commit, also empties the page.

Top module: `pgw_page_writer`

## Requirements
- R1: While reset is active and after its release, busy_o and mem_we_o are low until a commit is accepted.
- R2: A start pulse loads the row (start_addr_i[9:4]) and the in-page offset (start_addr_i[3:0]). Each accepted push stores its byte at the current offset and adds one to the offset modulo 16. The row is left unchanged.
- R3: If a 17th byte or later arrives before commit, the offset has wrapped, so that byte overwrites the slot filled sixteen pushes earlier. No byte reaches another row.
- R4: A commit with write protect low and at least one valid slot raises busy_o on the next clock. busy_o then stays high for exactly WR_CYCLES+16 cycles and falls on the cycle after the last slot is visited.
- R5: Array writes occur only after the WR_CYCLES wait. Slots are visited 0 to 15, one per cycle. Each write has mem_addr_o = {row, slot} and mem_wdata_o = the stored byte. Only valid slots are written, so the other bytes of the row keep their old contents.
- R6: A single pushed byte followed by commit produces exactly one array write, at the start address.
- R7: A commit while wp_i is high starts no write cycle, leaves busy_o low and discards the page. A later commit with no new pushes writes nothing.
- R8: An abort pulse empties the page. A start pulse that arrives before any commit also empties the page. Bytes discarded this way are never written.
- R9: While busy_o is high, push_i, start_i, abort_i and commit_i have no effect on the page being written or on the following state.
- R10: A commit while the page is empty leaves busy_o low and produces no array write.
- R11: After a write cycle completes the page is empty, so a repeated commit writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Opens a write command; loads start_addr_i |
| start_addr_i | input | 10 | Row in bits 9:4, in-page offset in bits 3:0 |
| push_i | input | 1 | One data byte received |
| push_data_i | input | 8 | Byte carried with push_i |
| commit_i | input | 1 | Stop that ends the command |
| abort_i | input | 1 | Drops the collected page |
| wp_i | input | 1 | Write protect, sampled at commit |
| busy_o | output | 1 | High for the whole self-timed cycle |
| mem_we_o | output | 1 | Array byte write enable |
| mem_addr_o | output | 10 | Array byte address |
| mem_wdata_o | output | 8 | Array write data |

## Verification
The bench drives several kinds of command. A one-byte command separates single-slot masking from a full-row write. A short burst at a mid-page offset shows that the neighbouring bytes stay intact. An 18-byte burst that starts near the end of a page shows whether the offset wraps inside the row or carries into the next one. Further commands check write protect, abort, a restart before commit, an empty commit and pushes made during busy, which tell real page discards apart from silently kept data. A behavioural reference model predicts busy, write enable, address and data on every clock, and an array image rebuilt from the write port confirms the final byte values.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_COPY = 2'd2
  } wr_state_e;
endpackage

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
  parameter int DATA_W = 8,
  parameter int OFS_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic [OFS_W-1:0]      load_ofs_i,
  input  logic                  push_i,
  input  logic [DATA_W-1:0]     push_data_i,
  input  logic                  clear_i,
  input  logic [OFS_W-1:0]      rd_slot_i,
  output logic [(1<<OFS_W)-1:0] mask_o,
  output logic [DATA_W-1:0]     rd_data_o
);
  localparam int SLOTS = 1 << OFS_W;

  logic [OFS_W-1:0]  ptr_q, ptr_d;
  logic [SLOTS-1:0]  mask_q;
  logic [DATA_W-1:0] data_q [SLOTS];

  // offset pointer: loaded on start, advanced per byte, wraps in the page
  always_comb begin
    ptr_d = ptr_q;
    if (load_i)      ptr_d = load_ofs_i;
    else if (push_i) ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic hit;
    assign hit = push_i && (ptr_q == OFS_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                mask_q[g] <= 1'b0;
      else if (load_i || clear_i) mask_q[g] <= 1'b0;
      else if (hit)              mask_q[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit) data_q[g] <= push_data_i;
    end
  end

  assign mask_o    = mask_q;
  assign rd_data_o = data_q[rd_slot_i];

  // R3: pointer wraps from the last slot back to slot zero
  p_ptr_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !load_i && ptr_q == OFS_W'(SLOTS-1)) |=> (ptr_q == '0));

  // R2: a push marks its slot valid
  p_push_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !load_i && !clear_i) |=> mask_q[$past(ptr_q)]);
endmodule

// File: rtl/pgw_timer.sv
module pgw_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                     cnt_d = load_val_i;
    else if (run_i && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R4: the wait counts down by exactly one per running cycle
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pgw_seq.sv
module pgw_seq
  import pgw_pkg::*;
#(
  parameter int OFS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic             timer_zero_i,
  output logic             busy_o,
  output logic             timer_load_o,
  output logic             timer_run_o,
  output logic             copy_o,
  output logic             done_o,
  output logic [OFS_W-1:0] slot_o
);
  localparam logic [OFS_W-1:0] LAST_SLOT = '1;

  wr_state_e        state_q, state_d;
  logic [OFS_W-1:0] slot_q, slot_d;

  always_comb begin
    state_d      = state_q;
    slot_d       = slot_q;
    timer_load_o = 1'b0;
    timer_run_o  = 1'b0;
    copy_o       = 1'b0;
    done_o       = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (go_i) begin
          state_d      = ST_WAIT;
          timer_load_o = 1'b1;
        end
      end
      ST_WAIT: begin
        timer_run_o = 1'b1;
        if (timer_zero_i) begin
          state_d = ST_COPY;
          slot_d  = '0;
        end
      end
      ST_COPY: begin
        copy_o = 1'b1;
        if (slot_q == LAST_SLOT) begin
          state_d = ST_IDLE;
          done_o  = 1'b1;
        end else begin
          slot_d = slot_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign slot_o = slot_q;

  // R5: copying starts at slot zero
  p_copy_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && timer_zero_i) |=> (state_q == ST_COPY && slot_q == '0));

  // R5: slots are visited in ascending order, one per cycle
  p_slot_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COPY && slot_q != LAST_SLOT) |=> (state_q == ST_COPY && slot_q == $past(slot_q) + 1'b1));

  // R4: the wait phase never ends before the timer reaches zero
  p_wait_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !timer_zero_i) |=> (state_q == ST_WAIT));
endmodule

// File: rtl/pgw_page_writer.sv
module pgw_page_writer #(
  parameter int ADDR_W    = 10,
  parameter int OFS_W     = 4,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 1250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              commit_i,
  input  logic              abort_i,
  input  logic              wp_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  localparam int ROW_W = ADDR_W - OFS_W;
  localparam int SLOTS = 1 << OFS_W;
  localparam int CNT_W = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1;
  localparam logic [CNT_W-1:0] WAIT_LOAD = CNT_W'(WR_CYCLES - 1);

  logic             busy;
  logic             load_ok, push_ok, commit_ok, go, discard, clear;
  logic             timer_load, timer_run, timer_zero, copy, done;
  logic [OFS_W-1:0] slot;
  logic [SLOTS-1:0] mask;
  logic [DATA_W-1:0] rd_data;
  logic [ROW_W-1:0] row_q;

  // input qualification: start > abort > commit > push, all gated by busy
  always_comb begin
    load_ok   = start_i && !busy;
    commit_ok = commit_i && !busy && !start_i && !abort_i;
    go        = commit_ok && !wp_i && (mask != '0);
    discard   = (abort_i && !busy && !start_i) || (commit_ok && wp_i);
    push_ok   = push_i && !busy && !start_i && !abort_i && !commit_i;
    clear     = discard || done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       row_q <= '0;
    else if (load_ok) row_q <= start_addr_i[ADDR_W-1:OFS_W];
  end

  pgw_page_buf #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_ok),
    .load_ofs_i (start_addr_i[OFS_W-1:0]),
    .push_i     (push_ok),
    .push_data_i(push_data_i),
    .clear_i    (clear),
    .rd_slot_i  (slot),
    .mask_o     (mask),
    .rd_data_o  (rd_data)
  );

  pgw_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (timer_load),
    .load_val_i(WAIT_LOAD),
    .run_i     (timer_run),
    .zero_o    (timer_zero)
  );

  pgw_seq #(.OFS_W(OFS_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_i        (go),
    .timer_zero_i(timer_zero),
    .busy_o      (busy),
    .timer_load_o(timer_load),
    .timer_run_o (timer_run),
    .copy_o      (copy),
    .done_o      (done),
    .slot_o      (slot)
  );

  assign busy_o      = busy;
  assign mem_we_o    = copy && mask[slot];
  assign mem_addr_o  = {row_q, slot};
  assign mem_wdata_o = rd_data;

  // R5: array writes only inside the busy window
  p_we_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_o);

  // R4: busy rises only after an accepted, unprotected commit
  p_busy_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(commit_i && !wp_i));

  // R7: a protected commit never starts a cycle
  p_wp_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && commit_i && wp_i) |=> !busy_o);

  // R9: the page is frozen while the cycle runs
  p_page_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done) |=> $stable(mask));

  // R11: the page is empty once the cycle finishes
  p_empty_after_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (mask == '0 && !busy_o));
endmodule

// File: tb/pgw_page_writer_bench.sv
module pgw_page_writer_bench;
  localparam int WR = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, push_i = 1'b0, commit_i = 1'b0, abort_i = 1'b0, wp_i = 1'b0;
  logic [9:0] start_addr_i = '0;
  logic [7:0] push_data_i = '0;
  logic       busy_o, mem_we_o;
  logic [9:0] mem_addr_o;
  logic [7:0] mem_wdata_o;

  always #4 clk = ~clk;

  pgw_page_writer #(.WR_CYCLES(WR)) u_pgw_page_writer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .push_i(push_i), .push_data_i(push_data_i), .commit_i(commit_i),
    .abort_i(abort_i), .wp_i(wp_i), .busy_o(busy_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
  );

  int checks = 0, fails = 0, wr_count = 0, busy_len = 0;
  logic [7:0] act_mem [1024];

  // behavioural reference model
  bit   m_mask [16];
  logic [7:0] m_data [16];
  int   m_row = 0, m_ptr = 0, m_state = 0, m_cnt = 0, m_slot = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void m_clear();
    for (int i = 0; i < 16; i++) m_mask[i] = 1'b0;
  endfunction

  function automatic bit m_any();
    for (int i = 0; i < 16; i++) if (m_mask[i]) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_clear(); m_row = 0; m_ptr = 0; m_state = 0; m_cnt = 0; m_slot = 0;
    end else if (m_state == 0) begin
      if (start_i) begin
        m_row = int'(start_addr_i) / 16; m_ptr = int'(start_addr_i) % 16; m_clear();
      end else if (abort_i) m_clear();
      else if (commit_i) begin
        if (wp_i) m_clear();
        else if (m_any()) begin m_state = 1; m_cnt = WR - 1; end
      end else if (push_i) begin
        m_mask[m_ptr] = 1'b1; m_data[m_ptr] = push_data_i; m_ptr = (m_ptr + 1) % 16;
      end
    end else if (m_state == 1) begin
      if (m_cnt == 0) begin m_state = 2; m_slot = 0; end
      else m_cnt--;
    end else begin
      if (m_slot == 15) begin m_state = 0; m_clear(); end
      else m_slot++;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_busy, exp_we;
      exp_busy = (m_state != 0);
      exp_we   = (m_state == 2) && m_mask[m_slot];
      check(busy_o == exp_busy, "R4", "busy", busy_o, exp_busy);
      check(mem_we_o == exp_we, "R5", "mem_we", mem_we_o, exp_we);
      if (exp_we && mem_we_o) begin
        check(mem_addr_o == 10'(m_row * 16 + m_slot), "R5", "addr", mem_addr_o, m_row * 16 + m_slot);
        check(mem_wdata_o == m_data[m_slot], "R5", "data", mem_wdata_o, m_data[m_slot]);
      end
      if (mem_we_o) begin act_mem[mem_addr_o] = mem_wdata_o; wr_count++; end
      if (busy_o) busy_len++;
    end
  end

  task automatic do_start(input logic [9:0] a);
    @(posedge clk); #2; start_i = 1'b1; start_addr_i = a;
    @(posedge clk); #2; start_i = 1'b0;
  endtask
  task automatic do_push(input logic [7:0] d);
    @(posedge clk); #2; push_i = 1'b1; push_data_i = d;
    @(posedge clk); #2; push_i = 1'b0;
  endtask
  task automatic do_commit();
    @(posedge clk); #2; commit_i = 1'b1;
    @(posedge clk); #2; commit_i = 1'b0;
  endtask
  task automatic do_abort();
    @(posedge clk); #2; abort_i = 1'b1;
    @(posedge clk); #2; abort_i = 1'b0;
  endtask
  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run did not finish");
    summary();
    $finish;
  end

  initial begin
    int w0;
    for (int i = 0; i < 1024; i++) act_mem[i] = 8'hEE;
    repeat (3) @(negedge clk);
    check(busy_o == 1'b0, "R1", "busy in reset", busy_o, 0);
    check(mem_we_o == 1'b0, "R1", "we in reset", mem_we_o, 0);
    @(posedge clk); #2; rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);

    // R10: empty commit
    do_commit();
    repeat (3) @(negedge clk);
    check(busy_o == 1'b0, "R10", "busy on empty commit", busy_o, 0);
    check(wr_count == 0, "R10", "writes on empty commit", wr_count, 0);

    // R6: single byte at the last address
    w0 = wr_count; busy_len = 0;
    do_start(10'h3FF); do_push(8'h5A); do_commit(); wait_idle();
    check(wr_count - w0 == 1, "R6", "single write count", wr_count - w0, 1);
    check(act_mem[10'h3FF] == 8'h5A, "R6", "single byte", act_mem[10'h3FF], 8'h5A);
    check(busy_len == WR + 16, "R4", "busy length", busy_len, WR + 16);

    // R2 / R5: short burst at mid-page offset
    w0 = wr_count;
    do_start(10'h125); do_push(8'hA0); do_push(8'hA1); do_push(8'hA2); do_commit(); wait_idle();
    check(act_mem[10'h125] == 8'hA0, "R2", "byte0", act_mem[10'h125], 8'hA0);
    check(act_mem[10'h127] == 8'hA2, "R2", "byte2", act_mem[10'h127], 8'hA2);
    check(act_mem[10'h124] == 8'hEE, "R5", "lower neighbour", act_mem[10'h124], 8'hEE);
    check(act_mem[10'h128] == 8'hEE, "R5", "upper neighbour", act_mem[10'h128], 8'hEE);
    check(wr_count - w0 == 3, "R5", "burst write count", wr_count - w0, 3);

    // R3: 18 bytes from offset 14 wrap within the row
    w0 = wr_count;
    do_start(10'h20E);
    for (int i = 0; i < 18; i++) do_push(8'(8'hB0 + i));
    do_commit(); wait_idle();
    check(act_mem[10'h20E] == 8'hC0, "R3", "slot14 overwritten", act_mem[10'h20E], 8'hC0);
    check(act_mem[10'h20F] == 8'hC1, "R3", "slot15 overwritten", act_mem[10'h20F], 8'hC1);
    check(act_mem[10'h200] == 8'hB2, "R3", "slot0 wrapped", act_mem[10'h200], 8'hB2);
    check(act_mem[10'h20D] == 8'hBF, "R3", "slot13", act_mem[10'h20D], 8'hBF);
    check(act_mem[10'h210] == 8'hEE, "R3", "next row untouched", act_mem[10'h210], 8'hEE);
    check(wr_count - w0 == 16, "R3", "full row count", wr_count - w0, 16);

    // R7: write protect discards the page
    w0 = wr_count;
    do_start(10'h050); do_push(8'h11); do_push(8'h22);
    wp_i = 1'b1; do_commit();
    repeat (2) @(negedge clk);
    check(busy_o == 1'b0, "R7", "busy under wp", busy_o, 0);
    wp_i = 1'b0; do_commit();
    repeat (3) @(negedge clk);
    check(busy_o == 1'b0, "R7", "busy after discard", busy_o, 0);
    check(wr_count == w0, "R7", "writes under wp", wr_count - w0, 0);
    check(act_mem[10'h050] == 8'hEE, "R7", "protected byte", act_mem[10'h050], 8'hEE);

    // R8: abort, and restart before commit
    w0 = wr_count;
    do_start(10'h060); do_push(8'h33); do_abort(); do_commit();
    repeat (3) @(negedge clk);
    check(busy_o == 1'b0, "R8", "busy after abort", busy_o, 0);
    check(wr_count == w0, "R8", "writes after abort", wr_count - w0, 0);
    do_start(10'h070); do_push(8'h44); do_start(10'h080); do_push(8'h55); do_commit(); wait_idle();
    check(act_mem[10'h070] == 8'hEE, "R8", "dropped by restart", act_mem[10'h070], 8'hEE);
    check(act_mem[10'h080] == 8'h55, "R8", "restart byte", act_mem[10'h080], 8'h55);
    check(wr_count - w0 == 1, "R8", "restart write count", wr_count - w0, 1);

    // R9 / R11: inputs ignored while busy, page empty afterwards
    w0 = wr_count;
    do_start(10'h090); do_push(8'h66); do_commit();
    do_push(8'h77); do_start(10'h0A0); do_abort(); do_commit();
    check(busy_o == 1'b1, "R9", "still busy", busy_o, 1);
    wait_idle();
    check(act_mem[10'h090] == 8'h66, "R9", "abort ignored", act_mem[10'h090], 8'h66);
    check(act_mem[10'h091] == 8'hEE, "R9", "push ignored", act_mem[10'h091], 8'hEE);
    check(act_mem[10'h0A0] == 8'hEE, "R9", "start ignored", act_mem[10'h0A0], 8'hEE);
    check(wr_count - w0 == 1, "R9", "busy write count", wr_count - w0, 1);
    do_commit();
    repeat (3) @(negedge clk);
    check(busy_o == 1'b0, "R11", "repeat commit busy", busy_o, 0);
    check(wr_count - w0 == 1, "R11", "repeat commit writes", wr_count - w0, 1);

    summary();
    $finish;
  end
endmodule